// File: doc/BRIEF.md
# Clock Output and Multiplier-Update Controller

This block owns one 8-bit control register and the logic around it. It decides what the external system-clock pin shows in each power mode, and when a newly written PLL multiplication factor takes effect. The CPU reaches the register through a simple select/strobe bus. The PLL, the speed-mode divider and the mode-transition sequencer live elsewhere. They are seen here only as the current power-mode code, a system-clock level, and a requested multiplier value with its write strobe.

The pin shows the running system clock in the running and sleeping modes. It is held high in the stopped modes and whenever the disable bit is set. It floats in hardware standby. A multiplier write either takes effect on the next clock edge, or waits in a pending register until the chip enters one of the mode-change states that allow a clock switch. The switching-mode bit chooses between the two.

Power-mode codes on `pmode`: 0 high-speed, 1 medium-speed, 2 subactive, 3 sleep, 4 subsleep, 5 software standby, 6 watch, 7 direct transition, 8 hardware standby. Codes 9 to 15 are unused and are treated like a stopped mode.

Top module: `clkout_mult_ctrl`

## Requirements
- R1: The register has this layout: bit 7 is the pin disable, bit 3 is the switching mode, and bits 2..0 are the divider select. A write with `sel` and `wr_en` high stores `wdata` at the next edge. `rdata` shows the register while `sel` is high and reads 0 otherwise.
- R2: Bits 6..4 always read as 0. Writing them has no effect.
- R3: After reset the register reads 0x00, and both the pending and the active multiplier are 0.
- R4: In hardware standby (code 8) the register is cleared at every edge, and bus writes are ignored. Software standby (code 5) keeps the register contents.
- R5: With the disable bit at 0, `pin_out` follows `sysclk` in codes 0 to 4.
- R6: With the disable bit at 0, `pin_out` is 1 in codes 5, 6 and 7, and in the unused codes 9 to 15.
- R7: With the disable bit at 1, `pin_out` is 1 in every code except 8.
- R8: In code 8, `pin_oe` is 0 whatever the register holds.
- R9: When `port_dir` is 0, `pin_oe` is 0 in every mode.
- R10: With the switching-mode bit at 0, a `mult_wr` stores `mult_req` as pending only, and `mult_active` does not change. The pending value becomes active at the edge where `pmode` first changes into code 2, 5 or 6.
- R11: With the switching-mode bit at 1, `mult_active` equals the written `mult_req` from the edge that takes the write.
- R12: `mult_active` does not change when the mode changes into any code other than 2, 5 or 6. It also does not change while the mode merely stays in code 2, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, used together with `sel` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| pmode | input | 4 | Current power-mode code |
| sysclk | input | 1 | System clock level to forward to the pin |
| port_dir | input | 1 | 1 when the shared pin is configured as an output |
| mult_wr | input | 1 | Strobe: a new multiplier value is being written |
| mult_req | input | 3 | Requested multiplier code |
| pin_out | output | 1 | Level driven onto the clock pin |
| pin_oe | output | 1 | Pin output enable; 0 means high impedance |
| mult_active | output | 3 | Multiplier code currently applied to the PLL |

## Verification
The pin function is checked across all sixteen mode codes, with the disable bit at each value. In every mode the system clock level is driven both low and high. This tells a forwarded clock apart from a held-high level, and tells either of those apart from a floating pin. A second sweep with the direction bit cleared separates the enable gating from the mode decode. The multiplier tests first write a deferred value. They then move through a non-committing mode, a committing mode, a stay inside a committing mode, and re-entry into each of the three committing modes. These steps tell entry-triggered commits apart from commits on every cycle, and apart from commits in the wrong modes. The last step is the immediate path.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    typedef enum logic [3:0] {
        PM_HIGH     = 4'd0,
        PM_MEDIUM   = 4'd1,
        PM_SUBACT   = 4'd2,
        PM_SLEEP    = 4'd3,
        PM_SUBSLEEP = 4'd4,
        PM_SWSTBY   = 4'd5,
        PM_WATCH    = 4'd6,
        PM_DIRECT   = 4'd7,
        PM_HWSTBY   = 4'd8
    } pmode_e;

    localparam int MODE_W     = 4;
    localparam int CTRL_W     = 8;
    localparam int OFF_BIT    = 7;
    localparam int SWMODE_BIT = 3;
    localparam int DIV_W      = 3;
    localparam int RSVD_W     = OFF_BIT - SWMODE_BIT - 1;

    typedef struct packed {
        logic             off;
        logic             swmode;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic clock_visible(input logic [MODE_W-1:0] m);
        return (m == PM_HIGH) || (m == PM_MEDIUM) || (m == PM_SUBACT) ||
               (m == PM_SLEEP) || (m == PM_SUBSLEEP);
    endfunction

    function automatic logic commit_mode(input logic [MODE_W-1:0] m);
        return (m == PM_SUBACT) || (m == PM_SWSTBY) || (m == PM_WATCH);
    endfunction
endpackage

// File: rtl/clkout_ctrl_reg.sv
module clkout_ctrl_reg
    import clkout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              hw_stby,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (hw_stby) begin
            ctrl_d = '0;
        end else if (wr_stb) begin
            ctrl_d.off    = wdata[OFF_BIT];
            ctrl_d.swmode = wdata[SWMODE_BIT];
            ctrl_d.div    = wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/clkout_pin.sv
module clkout_pin
    import clkout_pkg::*;
(
    input  logic [MODE_W-1:0] pmode,
    input  logic              off,
    input  logic              sysclk,
    input  logic              port_dir,
    output logic              pin_out,
    output logic              pin_oe
);
    always_comb begin
        pin_oe  = port_dir && (pmode != PM_HWSTBY);
        pin_out = 1'b1;
        if (pmode != PM_HWSTBY && !off && clock_visible(pmode))
            pin_out = sysclk;
    end
endmodule

// File: rtl/clkout_mult.sv
module clkout_mult
    import clkout_pkg::*;
#(
    parameter int MW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] pmode,
    input  logic              swmode,
    input  logic              wr,
    input  logic [MW-1:0]     req,
    output logic [MW-1:0]     active
);
    typedef struct packed {
        logic [MW-1:0]     pend;
        logic [MW-1:0]     act;
        logic [MODE_W-1:0] prev;
    } mstate_t;

    mstate_t st_d, st_q;
    logic    entering;

    always_comb begin
        st_d      = st_q;
        entering  = commit_mode(pmode) && (pmode != st_q.prev);
        st_d.prev = pmode;
        if (wr) st_d.pend = req;
        if (wr && swmode)  st_d.act = req;
        else if (entering) st_d.act = st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: '0, act: '0, prev: PM_HIGH};
        else        st_q <= st_d;
    end

    assign active = st_q.act;
endmodule

// File: rtl/clkout_mult_ctrl.sv
module clkout_mult_ctrl
    import clkout_pkg::*;
#(
    parameter int MW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    input  logic [MODE_W-1:0] pmode,
    input  logic              sysclk,
    input  logic              port_dir,
    input  logic              mult_wr,
    input  logic [MW-1:0]     mult_req,
    output logic              pin_out,
    output logic              pin_oe,
    output logic [MW-1:0]     mult_active
);
    ctrl_t             ctrl_q;
    logic [CTRL_W-1:0] ctrl_img;

    clkout_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (sel && wr_en),
        .wdata   (wdata),
        .hw_stby (pmode == PM_HWSTBY),
        .ctrl_q  (ctrl_q)
    );

    assign ctrl_img = {ctrl_q.off, {RSVD_W{1'b0}}, ctrl_q.swmode, ctrl_q.div};
    assign rdata    = sel ? ctrl_img : '0;

    clkout_pin u_pin (
        .pmode    (pmode),
        .off      (ctrl_q.off),
        .sysclk   (sysclk),
        .port_dir (port_dir),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    clkout_mult #(.MW(MW)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .pmode  (pmode),
        .swmode (ctrl_q.swmode),
        .wr     (mult_wr),
        .req    (mult_req),
        .active (mult_active)
    );
endmodule

// File: rtl/clkout_mult_ctrl_chk.sv
module clkout_mult_ctrl_chk
    import clkout_pkg::*;
#(
    parameter int MW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wdata,
    input logic [CTRL_W-1:0] ctrl_img,
    input logic [MODE_W-1:0] pmode,
    input logic              port_dir,
    input logic              mult_wr,
    input logic [MW-1:0]     mult_req,
    input logic              pin_out,
    input logic              pin_oe,
    input logic [MW-1:0]     mult_active
);
    localparam logic [CTRL_W-1:0] KEEP = CTRL_W'((1 << OFF_BIT) | (1 << SWMODE_BIT) | ((1 << DIV_W) - 1));

    assert_write_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && pmode != PM_HWSTBY) |=> ctrl_img == ($past(wdata) & KEEP));

    assert_hwstby_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == PM_HWSTBY) |=> ctrl_img == '0);

    assert_off_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_img[OFF_BIT] && pmode != PM_HWSTBY) |-> pin_out);

    assert_hwstby_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == PM_HWSTBY) |-> !pin_oe);

    assert_dir_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_dir |-> !pin_oe);

    assert_deferred_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_wr && !ctrl_img[SWMODE_BIT] && !commit_mode(pmode)) |=> $stable(mult_active));

    assert_immediate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_wr && ctrl_img[SWMODE_BIT]) |=> mult_active == $past(mult_req));
endmodule

bind clkout_mult_ctrl clkout_mult_ctrl_chk #(.MW(MW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .ctrl_img    (ctrl_img),
    .pmode       (pmode),
    .port_dir    (port_dir),
    .mult_wr     (mult_wr),
    .mult_req    (mult_req),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .mult_active (mult_active)
);

// File: tb/clkout_mult_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_mult_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pmode = 4'd0;
    logic       sysclk = 1'b0, port_dir = 1'b1;
    logic       mult_wr = 1'b0;
    logic [2:0] mult_req = '0;
    logic       pin_out, pin_oe;
    logic [2:0] mult_active;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [7:0] r_ctrl = '0;
    logic [2:0] r_pend = '0, r_act = '0;
    logic [3:0] r_prev = 4'd0;

    always #2 clk = ~clk;

    clkout_mult_ctrl u_clkout_mult_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pmode(pmode), .sysclk(sysclk), .port_dir(port_dir),
        .mult_wr(mult_wr), .mult_req(mult_req), .pin_out(pin_out),
        .pin_oe(pin_oe), .mult_active(mult_active));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // one clock edge; the reference model follows the requirements
    task automatic tick();
        logic [7:0] c_old;
        c_old = r_ctrl;
        if (pmode == 4'd8) r_ctrl = '0;
        else if (sel && wr_en) r_ctrl = wdata & 8'h8F;
        if (mult_wr && c_old[3]) r_act = mult_req;
        else if ((pmode == 4'd2 || pmode == 4'd5 || pmode == 4'd6) && pmode != r_prev) r_act = r_pend;
        if (mult_wr) r_pend = mult_req;
        r_prev = pmode;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; mult_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        sel = 1'b1; wr_en = 1'b1; wdata = v;
        tick();
    endtask

    task automatic read_check(input string tag);
        sel = 1'b1; #0.5;
        check(tag, rdata, r_ctrl);
        sel = 1'b0; #0.5;
        check({tag, " unselected"}, rdata, 0);
    endtask

    task automatic mode_to(input logic [3:0] m);
        pmode = m;
        tick();
    endtask

    task automatic mult_write(input logic [2:0] v);
        mult_wr = 1'b1; mult_req = v;
        tick();
    endtask

    task automatic t_reset();
        read_check("R3 reset register");
        check("R3 reset active multiplier", mult_active, 0);
    endtask

    task automatic t_readback();
        reg_write(8'hFF); read_check("R1 R2 write FF");
        reg_write(8'h75); read_check("R2 reserved ignored 75");
        reg_write(8'h8A); read_check("R1 write 8A");
        reg_write(8'h00); read_check("R1 write 00");
    endtask

    task automatic t_pin_sweep(input logic off);
        for (int m = 0; m < 16; m++) begin
            pmode = 4'd0; reg_write({off, 7'h00});
            pmode = 4'(m);
            for (int s = 0; s < 2; s++) begin
                logic eo, eoe;
                sysclk = s[0]; #0.5;
                eoe = (m != 8);
                if (m == 8 || off) eo = 1'b1;
                else if (m <= 4) eo = s[0];
                else eo = 1'b1;
                if (m == 8) check("R8 hw standby oe", pin_oe, 0);
                else check(off ? "R7 oe" : "R5 R6 oe", pin_oe, eoe);
                if (m != 8) begin
                    if (off) check("R7 disabled pin high", pin_out, eo);
                    else if (m <= 4) check("R5 clock forwarded", pin_out, eo);
                    else check("R6 stopped mode high", pin_out, eo);
                end
                #0.5;
            end
            tick();
            if (m == 8) read_check("R4 hw standby clears");
        end
        pmode = 4'd0; tick();
    endtask

    task automatic t_port_dir();
        port_dir = 1'b0;
        for (int m = 0; m < 9; m++) begin
            pmode = 4'(m); #0.5;
            check("R9 direction input floats", pin_oe, 0);
            #0.5;
            tick();
        end
        port_dir = 1'b1; pmode = 4'd0; tick();
    endtask

    task automatic t_standby_keep();
        pmode = 4'd0; reg_write(8'h8A);
        mode_to(4'd5); read_check("R4 software standby keeps");
        pmode = 4'd8; reg_write(8'hFF); read_check("R4 write ignored in hw standby");
        mode_to(4'd0); read_check("R4 after hw standby");
    endtask

    task automatic t_deferred();
        pmode = 4'd0; reg_write(8'h00);
        mult_write(3'd5);
        check("R10 deferred write holds active", mult_active, r_act);
        mode_to(4'd3); check("R12 sleep entry no commit", mult_active, r_act);
        mode_to(4'd7); check("R12 direct entry no commit", mult_active, r_act);
        mode_to(4'd5); check("R10 commit on software standby", mult_active, 3'd5);
        mult_write(3'd6); check("R12 staying in standby no commit", mult_active, 3'd5);
        mode_to(4'd5); check("R12 still in standby", mult_active, 3'd5);
        mode_to(4'd0); mode_to(4'd6); check("R10 commit on watch", mult_active, 3'd6);
        mode_to(4'd0); mult_write(3'd3);
        check("R10 pending only", mult_active, 3'd6);
        mode_to(4'd2); check("R10 commit on subactive", mult_active, 3'd3);
        mode_to(4'd0);
    endtask

    task automatic t_immediate();
        pmode = 4'd0; reg_write(8'h08);
        mult_write(3'd7); check("R11 immediate 7", mult_active, 3'd7);
        mult_write(3'd1); check("R11 immediate 1", mult_active, 3'd1);
        check("R11 model agrees", mult_active, r_act);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_pin_sweep(1'b0);
        t_pin_sweep(1'b1);
        t_port_dir();
        t_standby_keep();
        t_deferred();
        t_immediate();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule